// File: doc/BRIEF.md
# Keyed Windowed Watchdog Timer

This block is a watchdog for a system-on-chip. A slow time base reaches it as a one-cycle enable pulse, `slow_ce_i`, in the system clock domain. A prescaler divides those pulses by `PRESC_DIV`, which defaults to 128. With a 32768 Hz source this gives 256 counting steps per second. Each step lowers a `CNT_W`-bit down-counter by one. With the default width of 12 bits, the longest period is 4096 steps, which is 16 seconds. Software picks a timeout of s seconds by loading s*256-1, limited to the counter's maximum.

Software must refresh the counter before it reaches zero. It does this by writing a keyed restart command to the control register. A restart is accepted only when the current count has fallen to or below a programmable window value, so a refresh that comes too early is treated as a fault. A fault or an expiry can drive a reset output for one clock.

The configuration register accepts a single write after reset and then locks. It holds the reload value, the window value and three control bits: reset enable, freeze under debug, and a switch that turns the watchdog off. A status register reports three sticky fault flags and the live count. Reading the status register clears the flags.

Top module: `wdog_top`

## Requirements
- R1: After reset the count is all ones, all status flags are clear, the reset output is low, and the configuration reads back with reload and window both all ones, reset enable set, and the freeze and off bits clear.
- R2: The count drops by exactly one on every `PRESC_DIV`-th slow-clock pulse. The prescaler phase carries over from one step to the next.
- R3: Only the first write to the configuration register after reset takes effect. Any later write leaves the readback value unchanged.
- R4: A control write at byte offset 0x0 that carries 0xA5 in bits 31:24 and a 1 in bit 0 is a restart command. An accepted restart loads the count from the reload field.
- R5: A control write with any other value in bits 31:24 leaves the count unchanged and sets status bit 2.
- R6: A restart is accepted only if the count is less than or equal to the window field. A window of all ones therefore accepts a restart at any time. A restart with a higher count leaves the count unchanged, sets status bit 1, and pulses the reset output if reset is enabled.
- R7: When a counting step brings the count to zero, status bit 0 is set. The count then stays at zero until a restart is accepted.
- R8: The reset output is a single-clock pulse on expiry or on a window fault, but only while reset enable is set and the off bit is clear. It never rises while reset enable is clear.
- R9: While the off bit is set, the count does not change on slow pulses and the reset output stays low. A keyed restart still reloads the count, with no window check.
- R10: While the freeze bit is set and `dbg_req_i` is high, both the count and the prescaler phase hold. When the freeze bit is clear, `dbg_req_i` has no effect.
- R11: Register map:
  - Configuration at byte offset 0x4:
    - reload in bits CNT_W-1:0
    - reset enable in bit 12
    - freeze in bit 13
    - off in bit 14
    - window in bits 16+CNT_W-1:16
  - Status at byte offset 0x8:
    - expiry flag in bit 0
    - window-fault flag in bit 1
    - bad-key flag in bit 2
    - live count in bits 16+CNT_W-1:16
  - Read data appears one clock after the read.
- R12: A status read clears all three flags. A flag event in the same cycle as the read takes priority, so that flag stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| slow_ce_i | input | 1 | One-cycle pulse for each slow-clock period |
| dbg_req_i | input | 1 | Debug request; stops counting when the freeze bit is set |
| bus_sel_i | input | 1 | Bus access strobe |
| bus_we_i | input | 1 | 1 for a write, 0 for a read |
| bus_addr_i | input | 4 | Byte offset of the register |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Registered read data |
| wdt_rst_o | output | 1 | Reset request pulse |

## Verification
The assertions check these properties on every cycle:
- Once locked, the configuration word never changes.
- Outside a restart, the count only holds or steps down by one, and it stays at zero once it gets there.
- The count holds while frozen for debug.
- The reset pulse lasts a single clock.
- The reset pulse stays low whenever the off bit or a cleared reset enable has been in force for at least one cycle.

Only the bench scenarios can show the remaining behaviour:
- Whether a restart is accepted or refused for each pairing of count and window.
- Which flags are set and cleared.
- How many pulses each fault produces.
- The exact step on which the prescaler fires.
The bench sweeps every count from 1 to 15 against every window from 0 to 15, in a 4-bit configuration that steps once every four slow pulses.

// File: rtl/wdog_pkg.sv
package wdog_pkg;

    // Restart key, expected in the top byte of a control write
    localparam logic [7:0] RESTART_KEY   = 8'hA5;
    localparam int unsigned KEY_LSB      = 24;
    localparam int unsigned RESTART_BIT  = 0;

    // Configuration word layout
    localparam int unsigned CFG_RST_EN   = 12;
    localparam int unsigned CFG_FREEZE   = 13;
    localparam int unsigned CFG_OFF      = 14;
    localparam int unsigned CFG_WIN_LSB  = 16;

    // Status word layout
    localparam int unsigned ST_EXPIRED   = 0;
    localparam int unsigned ST_WIN_FAULT = 1;
    localparam int unsigned ST_BAD_KEY   = 2;
    localparam int unsigned ST_CNT_LSB   = 16;

    // Register select, taken from byte-address bits 3:2
    typedef enum logic [1:0] {
        SEL_CTRL = 2'd0,
        SEL_CFG  = 2'd1,
        SEL_STAT = 2'd2,
        SEL_NONE = 2'd3
    } reg_sel_e;

endpackage

// File: rtl/wdog_prescaler.sv
module wdog_prescaler #(
    parameter int unsigned DIV = 128
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic slow_ce_i,
    input  logic run_i,
    output logic tick_o
);

    localparam int unsigned PH_W = (DIV > 1) ? $clog2(DIV) : 1;
    localparam logic [PH_W-1:0] PH_LAST = PH_W'(DIV - 1);

    typedef struct packed {
        logic [PH_W-1:0] phase;
    } pre_state_t;

    pre_state_t st_d, st_q;

    generate
        if (DIV <= 1) begin : g_bypass
            // With a divide ratio of one, every qualified slow pulse is a step
            always_comb begin
                st_d   = st_q;
                tick_o = run_i && slow_ce_i;
            end
        end else begin : g_divide
            always_comb begin
                st_d   = st_q;
                tick_o = 1'b0;
                if (run_i && slow_ce_i) begin
                    if (st_q.phase == PH_LAST) begin
                        st_d.phase = '0;
                        tick_o     = 1'b1;
                    end else begin
                        st_d.phase = st_q.phase + 1'b1;
                    end
                end
            end
        end
    endgenerate

    always_ff @(posedge clk_i) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

endmodule

// File: rtl/wdog_counter.sv
module wdog_counter #(
    parameter int unsigned CNT_W = 12
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             tick_i,
    input  logic             restart_i,
    input  logic [CNT_W-1:0] reload_i,
    input  logic [CNT_W-1:0] window_i,
    input  logic             off_i,
    input  logic             rst_en_i,
    output logic [CNT_W-1:0] count_o,
    output logic             expire_evt_o,
    output logic             win_evt_o,
    output logic             rst_pulse_o
);

    localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

    typedef struct packed {
        logic [CNT_W-1:0] count;
        logic             pulse;
    } cnt_state_t;

    cnt_state_t st_d, st_q;

    always_comb begin
        st_d         = st_q;
        expire_evt_o = 1'b0;
        win_evt_o    = 1'b0;

        // A restart command takes priority over a counting step in the same cycle
        if (restart_i) begin
            if (off_i || (st_q.count <= window_i)) begin
                st_d.count = reload_i;
            end else begin
                win_evt_o = 1'b1;
            end
        end else if (tick_i && (st_q.count != '0)) begin
            st_d.count = st_q.count - 1'b1;
            if (st_q.count == CNT_ONE) expire_evt_o = 1'b1;
        end

        // The !pulse term keeps every request to a single cycle
        st_d.pulse = (expire_evt_o || win_evt_o) && rst_en_i && !off_i && !st_q.pulse;
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            st_q.count <= '1;
            st_q.pulse <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign count_o     = st_q.count;
    assign rst_pulse_o = st_q.pulse;

endmodule

// File: rtl/wdog_top.sv
module wdog_top
    import wdog_pkg::*;
#(
    parameter int unsigned CNT_W     = 12,
    parameter int unsigned PRESC_DIV = 128
) (
    input  logic        clk_i,
    input  logic        rst_ni,
    input  logic        slow_ce_i,
    input  logic        dbg_req_i,
    input  logic        bus_sel_i,
    input  logic        bus_we_i,
    input  logic [3:0]  bus_addr_i,
    input  logic [31:0] bus_wdata_i,
    output logic [31:0] bus_rdata_o,
    output logic        wdt_rst_o
);

    typedef struct packed {
        logic [CNT_W-1:0] reload;
        logic [CNT_W-1:0] window;
        logic             rst_en;
        logic             freeze;
        logic             off;
        logic             locked;
        logic             f_expired;
        logic             f_win;
        logic             f_key;
        logic [31:0]      rdata;
    } top_state_t;

    top_state_t st_d, st_q;

    reg_sel_e         sel_w;
    logic             wr_ctrl_w;
    logic             wr_cfg_w;
    logic             rd_w;
    logic             rd_stat_w;
    logic             key_ok_w;
    logic             restart_w;
    logic             bad_key_w;
    logic             run_w;
    logic             tick_w;
    logic [CNT_W-1:0] count_w;
    logic             expire_evt_w;
    logic             win_evt_w;
    logic             rst_pulse_w;
    logic [31:0]      cfg_word_w;
    logic [31:0]      stat_word_w;

    // Bus decode
    always_comb begin
        sel_w     = reg_sel_e'(bus_addr_i[3:2]);
        wr_ctrl_w = bus_sel_i && bus_we_i && (sel_w == SEL_CTRL);
        wr_cfg_w  = bus_sel_i && bus_we_i && (sel_w == SEL_CFG);
        rd_w      = bus_sel_i && !bus_we_i;
        rd_stat_w = rd_w && (sel_w == SEL_STAT);
        key_ok_w  = (bus_wdata_i[KEY_LSB +: 8] == RESTART_KEY);
        restart_w = wr_ctrl_w && key_ok_w && bus_wdata_i[RESTART_BIT];
        bad_key_w = wr_ctrl_w && !key_ok_w;
        run_w     = !st_q.off && !(st_q.freeze && dbg_req_i);
    end

    // Readback words
    always_comb begin
        cfg_word_w                           = '0;
        cfg_word_w[CNT_W-1:0]                = st_q.reload;
        cfg_word_w[CFG_RST_EN]               = st_q.rst_en;
        cfg_word_w[CFG_FREEZE]               = st_q.freeze;
        cfg_word_w[CFG_OFF]                  = st_q.off;
        cfg_word_w[CFG_WIN_LSB +: CNT_W]     = st_q.window;

        stat_word_w                          = '0;
        stat_word_w[ST_EXPIRED]              = st_q.f_expired;
        stat_word_w[ST_WIN_FAULT]            = st_q.f_win;
        stat_word_w[ST_BAD_KEY]              = st_q.f_key;
        stat_word_w[ST_CNT_LSB +: CNT_W]     = count_w;
    end

    wdog_prescaler #(
        .DIV (PRESC_DIV)
    ) u_prescaler (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .slow_ce_i (slow_ce_i),
        .run_i     (run_w),
        .tick_o    (tick_w)
    );

    wdog_counter #(
        .CNT_W (CNT_W)
    ) u_counter (
        .clk_i        (clk_i),
        .rst_ni       (rst_ni),
        .tick_i       (tick_w),
        .restart_i    (restart_w),
        .reload_i     (st_q.reload),
        .window_i     (st_q.window),
        .off_i        (st_q.off),
        .rst_en_i     (st_q.rst_en),
        .count_o      (count_w),
        .expire_evt_o (expire_evt_w),
        .win_evt_o    (win_evt_w),
        .rst_pulse_o  (rst_pulse_w)
    );

    // Next-state logic for the register file
    always_comb begin
        st_d = st_q;

        // Configuration: accepts one write, then locks
        if (wr_cfg_w && !st_q.locked) begin
            st_d.reload = bus_wdata_i[CNT_W-1:0];
            st_d.window = bus_wdata_i[CFG_WIN_LSB +: CNT_W];
            st_d.rst_en = bus_wdata_i[CFG_RST_EN];
            st_d.freeze = bus_wdata_i[CFG_FREEZE];
            st_d.off    = bus_wdata_i[CFG_OFF];
            st_d.locked = 1'b1;
        end

        // Sticky flags: cleared by a status read, and a new event in the same cycle wins
        st_d.f_expired = (st_q.f_expired && !rd_stat_w) || expire_evt_w;
        st_d.f_win     = (st_q.f_win     && !rd_stat_w) || win_evt_w;
        st_d.f_key     = (st_q.f_key     && !rd_stat_w) || bad_key_w;

        if (rd_w) begin
            unique case (sel_w)
                SEL_CFG:  st_d.rdata = cfg_word_w;
                SEL_STAT: st_d.rdata = stat_word_w;
                default:  st_d.rdata = '0;
            endcase
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            st_q        <= '0;
            st_q.reload <= '1;
            st_q.window <= '1;
            st_q.rst_en <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign bus_rdata_o = st_q.rdata;
    assign wdt_rst_o   = rst_pulse_w;

endmodule

// File: rtl/wdog_chk.sv
module wdog_chk #(
    parameter int unsigned CNT_W = 12
) (
    input logic             clk_i,
    input logic             rst_ni,
    input logic [CNT_W-1:0] count_i,
    input logic             restart_i,
    input logic             locked_i,
    input logic [31:0]      cfg_word_i,
    input logic             off_i,
    input logic             rst_en_i,
    input logic             freeze_i,
    input logic             dbg_i,
    input logic             wdt_rst_i
);

    // R3: a locked configuration never changes again
    p_cfg_frozen_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        locked_i |=> $stable(cfg_word_i));

    // R2: without a restart the count holds or steps down by exactly one
    p_single_step_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !restart_i |=> ((count_i == $past(count_i)) || ((count_i + 1'b1) == $past(count_i))));

    // R7: zero is held until a restart
    p_hold_zero_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ((count_i == '0) && !restart_i) |=> (count_i == '0));

    // R8: the reset request lasts one clock
    p_pulse_width_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        wdt_rst_i |=> !wdt_rst_i);

    // R8: no request while reset enable has been clear
    p_no_rst_when_masked_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!rst_en_i && $past(!rst_en_i)) |-> !wdt_rst_i);

    // R9: no request while the watchdog has been off
    p_off_silent_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (off_i && $past(off_i)) |-> !wdt_rst_i);

    // R10: frozen under debug request
    p_dbg_freeze_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (freeze_i && dbg_i && !restart_i) |=> $stable(count_i));

endmodule

bind wdog_top wdog_chk #(
    .CNT_W (CNT_W)
) u_wdog_chk (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .count_i    (count_w),
    .restart_i  (restart_w),
    .locked_i   (st_q.locked),
    .cfg_word_i (cfg_word_w),
    .off_i      (st_q.off),
    .rst_en_i   (st_q.rst_en),
    .freeze_i   (st_q.freeze),
    .dbg_i      (dbg_req_i),
    .wdt_rst_i  (wdt_rst_o)
);

// File: tb/wdog_top_tb_top.sv
module wdog_top_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int CNT_W      = 4;
    localparam int DIV        = 4;
    localparam int CMAX       = (1 << CNT_W) - 1;

    localparam logic [3:0]  A_CTRL  = 4'h0;
    localparam logic [3:0]  A_CFG   = 4'h4;
    localparam logic [3:0]  A_STAT  = 4'h8;
    localparam logic [31:0] RESTART = 32'hA500_0001;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        slow_ce = 1'b0;
    logic        dbg_req = 1'b0;
    logic        sel = 1'b0;
    logic        we = 1'b0;
    logic [3:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        wdt_rst;

    int n_chk = 0;
    int n_fail = 0;
    int pulses = 0;
    int run_len = 0;
    int max_run = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    wdog_top #(
        .CNT_W     (CNT_W),
        .PRESC_DIV (DIV)
    ) dut_i (
        .clk_i       (clk),
        .rst_ni      (rst_n),
        .slow_ce_i   (slow_ce),
        .dbg_req_i   (dbg_req),
        .bus_sel_i   (sel),
        .bus_we_i    (we),
        .bus_addr_i  (addr),
        .bus_wdata_i (wdata),
        .bus_rdata_o (rdata),
        .wdt_rst_o   (wdt_rst)
    );

    always @(negedge clk) begin
        if (wdt_rst) begin
            pulses++;
            run_len++;
            if (run_len > max_run) max_run = run_len;
        end else begin
            run_len = 0;
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=0x%08h expected=0x%08h", tag, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic bus_wr(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        sel = 1'b1; we = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        sel = 1'b0; we = 1'b0;
    endtask

    task automatic bus_rd(input logic [3:0] a, output logic [31:0] d);
        @(negedge clk);
        sel = 1'b1; we = 1'b0; addr = a;
        @(negedge clk);
        d = rdata;
        sel = 1'b0;
    endtask

    task automatic slow(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            slow_ce = 1'b1;
            @(negedge clk);
            slow_ce = 1'b0;
        end
    endtask

    task automatic steps(input int n);
        slow(n * DIV);
    endtask

    function automatic logic [31:0] mk_cfg(input int r, input int w, input bit en,
                                           input bit frz, input bit off);
        return 32'(r) | (32'(en) << 12) | (32'(frz) << 13) | (32'(off) << 14) | (32'(w) << 16);
    endfunction

    function automatic logic [31:0] st_word(input int cnt, input int flags);
        return (32'(cnt) << 16) | 32'(flags);
    endfunction

    initial begin
        logic [31:0] v;
        int p0;
        int r;

        // R1 and R11: reset state and readback layout
        do_reset();
        bus_rd(A_STAT, v);  chk("R1 status after reset", v, st_word(CMAX, 0));
        bus_rd(A_CFG, v);   chk("R11 config default", v, mk_cfg(CMAX, CMAX, 1, 0, 0));
        chk("R1 reset output idle", 32'(pulses), 32'd0);

        // R2: one step for every DIV slow pulses
        slow(DIV - 1);
        bus_rd(A_STAT, v);  chk("R2 before divide completes", v, st_word(CMAX, 0));
        slow(1);
        bus_rd(A_STAT, v);  chk("R2 first step", v, st_word(CMAX - 1, 0));
        steps(1);
        bus_rd(A_STAT, v);  chk("R2 second step", v, st_word(CMAX - 2, 0));

        // R5 and R12: wrong key sets a flag, which a read clears
        bus_wr(A_CTRL, 32'h5A00_0001);
        bus_rd(A_STAT, v);  chk("R5 bad key flagged", v, st_word(CMAX - 2, 4));
        bus_rd(A_STAT, v);  chk("R12 flag cleared by read", v, st_word(CMAX - 2, 0));

        // R3: write-once configuration
        bus_wr(A_CFG, 32'h0003_100A);
        bus_rd(A_CFG, v);   chk("R3 first write taken", v, 32'h0003_100A);
        bus_wr(A_CFG, 32'h0000_4005);
        bus_rd(A_CFG, v);   chk("R3 second write ignored", v, 32'h0003_100A);

        // R7 and R8: expiry with reset enabled
        do_reset();
        bus_wr(A_CFG, mk_cfg(3, CMAX, 1, 0, 0));
        bus_wr(A_CTRL, RESTART);
        bus_rd(A_STAT, v);  chk("R4 reload to 3", v, st_word(3, 0));
        p0 = pulses; max_run = 0;
        steps(3);
        bus_rd(A_STAT, v);  chk("R7 expiry flag", v, st_word(0, 1));
        chk("R8 one pulse on expiry", 32'(pulses - p0), 32'd1);
        chk("R8 pulse width", 32'(max_run), 32'd1);
        steps(2);
        bus_rd(A_STAT, v);  chk("R7 holds at zero", v, st_word(0, 0));
        chk("R8 no further pulse", 32'(pulses - p0), 32'd1);
        bus_wr(A_CTRL, RESTART);
        bus_rd(A_STAT, v);  chk("R7 restart recovers", v, st_word(3, 0));

        // R8: reset enable clear suppresses every request
        do_reset();
        bus_wr(A_CFG, mk_cfg(2, 0, 0, 0, 0));
        p0 = pulses;
        bus_wr(A_CTRL, RESTART);
        bus_rd(A_STAT, v);  chk("R6 early restart refused", v, st_word(CMAX, 2));
        steps(CMAX);
        bus_rd(A_STAT, v);  chk("R7 expiry with masking", v, st_word(0, 1));
        chk("R8 masked pulses", 32'(pulses - p0), 32'd0);
        bus_wr(A_CTRL, RESTART);
        bus_rd(A_STAT, v);  chk("R6 restart at window edge", v, st_word(2, 0));

        // R9: off bit
        do_reset();
        bus_wr(A_CFG, mk_cfg(5, 0, 1, 0, 1));
        p0 = pulses;
        steps(3);
        bus_rd(A_STAT, v);  chk("R9 no counting while off", v, st_word(CMAX, 0));
        bus_wr(A_CTRL, RESTART);
        bus_rd(A_STAT, v);  chk("R9 restart reloads while off", v, st_word(5, 0));
        steps(2);
        bus_rd(A_STAT, v);  chk("R9 still frozen", v, st_word(5, 0));
        chk("R9 no pulse while off", 32'(pulses - p0), 32'd0);

        // R10: freeze under debug request
        do_reset();
        bus_wr(A_CFG, mk_cfg(CMAX, CMAX, 1, 1, 0));
        dbg_req = 1'b1;
        steps(2);
        bus_rd(A_STAT, v);  chk("R10 frozen by debug", v, st_word(CMAX, 0));
        dbg_req = 1'b0;
        steps(2);
        bus_rd(A_STAT, v);  chk("R10 resumes", v, st_word(CMAX - 2, 0));
        do_reset();
        bus_wr(A_CFG, mk_cfg(CMAX, CMAX, 1, 0, 0));
        dbg_req = 1'b1;
        steps(1);
        dbg_req = 1'b0;
        bus_rd(A_STAT, v);  chk("R10 debug ignored without freeze", v, st_word(CMAX - 1, 0));

        // R4, R6, R8: sweep of count against window
        for (int c = 1; c <= CMAX; c++) begin
            for (int w = 0; w <= CMAX; w++) begin
                r = ((c * 7 + w) % CMAX) + 1;
                do_reset();
                bus_wr(A_CFG, mk_cfg(r, w, 1, 0, 0));
                steps(CMAX - c);
                p0 = pulses;
                bus_wr(A_CTRL, RESTART);
                bus_rd(A_STAT, v);
                if (c <= w) begin
                    chk("R4 accepted restart", v, st_word(r, 0));
                    chk("R8 no pulse on accept", 32'(pulses - p0), 32'd0);
                end else begin
                    chk("R6 refused restart", v, st_word(c, 2));
                    chk("R8 pulse on window fault", 32'(pulses - p0), 32'd1);
                end
            end
        end

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end

endmodule